// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block is the priority core of a per-processor interrupt controller. It keeps three 256-bit maps: the requests waiting for service, the vectors the processor has accepted but not yet finished, and for each vector a flag that tells whether it was signalled by level or by edge. Vectors are ranked by number. The upper nibble of a vector is its priority class, so each class holds 16 vectors.

Software sets a task priority byte and a spurious register. Bit 8 of the spurious register enables the controller, and bits 7:0 give the vector that is returned when an acknowledge cannot be granted. From the task priority and the highest vector in service the block forms a processor priority. It drives a level interrupt line to the processor whenever a pending request is in a higher class than that priority. When the processor acknowledges, the block answers with a vector in the same cycle and moves that vector from pending to in-service. An end-of-interrupt strobe retires the highest vector in service.

Top module: `vip_ctrl`

## Requirements
- R1: After a synchronous reset the task priority is 0x00 and the spurious register is 0x0FF, so the controller is disabled and the spurious vector is 0xFF. All three maps are empty, `irq` is 0 and `ppr` is 0x00.
- R2: A write to the spurious register keeps bits 8:0 of `spur_wdata` and drops the rest. Bit 8 is the enable. While it is 0, `irq` stays 0, and an acknowledge returns bits 7:0 and changes no state.
- R3: A `set_vld` pulse sets the request bit of `set_vec`. It also writes `set_level` into that vector's trigger flag (1 = level, 0 = edge), and a later arrival of the same vector overwrites the flag. `ack_level` shows the trigger flag of the vector an acknowledge grants, and is 0 when the acknowledge is refused.
- R4: `ppr` equals the full task priority byte when the task priority's upper nibble is greater than or equal to the class of the highest in-service vector. Otherwise `ppr` is that class followed by four zero bits. An empty in-service map counts as class 0.
- R5: `irq` asks for service when all of these hold: the controller is enabled, a request is pending, and either `ppr` is 0 or the upper nibble of the highest pending vector is strictly greater than the upper nibble of `ppr`.
- R6: `irq` is a register. Its value is decided from the state held during one cycle, so a change in state shows on `irq` one clock after the state register itself changes.
- R7: An acknowledge is granted when none of the refusal conditions in R8 hold. A granted acknowledge returns the highest-numbered pending vector on `ack_vec` in the same cycle, clears its request bit and sets its in-service bit.
- R8: An acknowledge is refused in three cases: the controller is disabled, nothing is pending, or the task priority is nonzero and the highest pending vector is less than or equal to the whole task priority byte. A refused acknowledge returns spurious bits 7:0 and leaves the request and in-service maps unchanged.
- R9: End-of-interrupt clears only the highest set in-service bit. When the in-service map is empty it does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| set_vld | input | 1 | A new request arrives this cycle |
| set_vec | input | 8 | Vector of the arriving request |
| set_level | input | 1 | 1 = level triggered, 0 = edge triggered |
| tpr_we | input | 1 | Write strobe for the task priority |
| tpr_wdata | input | 8 | New task priority |
| spur_we | input | 1 | Write strobe for the spurious register |
| spur_wdata | input | 32 | Write data; only bits 8:0 are kept |
| ack | input | 1 | Processor acknowledge strobe |
| ack_vec | output | 8 | Vector returned for the acknowledge in this cycle |
| ack_level | output | 1 | Trigger flag of the granted vector |
| eoi | input | 1 | End-of-interrupt strobe |
| irq | output | 1 | Registered interrupt request to the processor |
| ppr | output | 8 | Current processor priority |

## Verification
If the in-service map holds a wrong bit, it shows on `ppr` in the cycle after the fault, because `ppr` is combinational from the map. A wrong bit in the request map shows on `ack_vec` at the next acknowledge, and on `irq` one clock after the bad state appears. A wrong trigger flag is only visible through `ack_level` when that vector is granted. For this reason the stimulus acknowledges vectors whose flags were written and then overwritten. It also retires in-service vectors one at a time, so that an end-of-interrupt that clears the wrong bit moves `ppr` to a value different from the expected one.

// File: rtl/vip_pkg.sv
package vip_pkg;

    localparam int VEC_W   = 8;
    localparam int NVEC    = 1 << VEC_W;
    localparam int CLS_LSB = 4;
    localparam int SPUR_W  = 9;
    localparam int EN_BIT  = 8;

    typedef logic [VEC_W-1:0] vec_t;

    typedef struct packed {
        logic found;
        vec_t vec;
    } hit_t;

    typedef struct packed {
        logic take;
        vec_t vec;
        logic lvl;
    } ack_res_t;

    function automatic logic [VEC_W-CLS_LSB-1:0] cls_of(input vec_t v);
        return v[VEC_W-1:CLS_LSB];
    endfunction

    function automatic logic irq_wanted(input logic en, input hit_t pend, input vec_t prio);
        return en && pend.found &&
               ((prio == '0) || (cls_of(pend.vec) > cls_of(prio)));
    endfunction

    function automatic logic ack_granted(input logic en, input hit_t pend, input vec_t task_pri);
        return en && pend.found && !((task_pri != '0) && (pend.vec <= task_pri));
    endfunction

endpackage

// File: rtl/vip_hi_find.sv
module vip_hi_find #(
    parameter int N = 256,
    parameter int W = 32
) (
    input  logic [N-1:0]         bits,
    output logic                 found,
    output logic [$clog2(N)-1:0] idx
);
    localparam int NW = N / W;
    localparam int IW = $clog2(N);
    localparam int BW = $clog2(W);

    logic [NW-1:0]    any_w;
    logic [NW*BW-1:0] pos_flat;

    for (genvar w = 0; w < NW; w++) begin : g_word
        logic [BW-1:0] pos_w;
        always_comb begin
            pos_w = '0;
            for (int b = 0; b < W; b++)
                if (bits[w*W+b]) pos_w = BW'(b);
        end
        assign any_w[w] = |bits[w*W +: W];
        assign pos_flat[w*BW +: BW] = pos_w;
    end

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int w = 0; w < NW; w++) begin
            if (any_w[w]) begin
                found = 1'b1;
                idx   = IW'(w * W) | IW'(pos_flat[w*BW +: BW]);
            end
        end
    end
endmodule

// File: rtl/vip_ppr.sv
module vip_ppr
    import vip_pkg::*;
#(
    parameter int CLS = CLS_LSB
) (
    input  vec_t tpr,
    input  hit_t isr_top,
    output vec_t ppr
);
    localparam int HI_W = VEC_W - CLS;

    logic [HI_W-1:0] svc_cls;

    assign svc_cls = isr_top.found ? isr_top.vec[VEC_W-1:CLS] : '0;
    assign ppr     = (tpr[VEC_W-1:CLS] >= svc_cls) ? tpr : {svc_cls, {CLS{1'b0}}};
endmodule

// File: rtl/vip_ctrl.sv
module vip_ctrl
    import vip_pkg::*;
#(
    parameter int WORD_W = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        set_vld,
    input  logic [7:0]  set_vec,
    input  logic        set_level,
    input  logic        tpr_we,
    input  logic [7:0]  tpr_wdata,
    input  logic        spur_we,
    input  logic [31:0] spur_wdata,
    input  logic        ack,
    output logic [7:0]  ack_vec,
    output logic        ack_level,
    input  logic        eoi,
    output logic        irq,
    output logic [7:0]  ppr
);
    localparam int NWORD = NVEC / WORD_W;

    logic [NVEC-1:0]   req_q, svc_q, trg_q;
    logic [NVEC-1:0]   req_d, svc_d, trg_d;
    vec_t              tpr_q;
    logic [SPUR_W-1:0] spur_q;
    logic              irq_q;
    logic              sw_en;
    hit_t              req_top, svc_top;
    vec_t              ppr_w;
    ack_res_t          ack_r;
    logic              unused_spur;

    assign unused_spur = ^spur_wdata[31:SPUR_W];
    assign sw_en       = spur_q[EN_BIT];

    vip_hi_find #(.N(NVEC), .W(WORD_W)) u_req_find (
        .bits(req_q), .found(req_top.found), .idx(req_top.vec));

    vip_hi_find #(.N(NVEC), .W(WORD_W)) u_svc_find (
        .bits(svc_q), .found(svc_top.found), .idx(svc_top.vec));

    vip_ppr u_ppr (.tpr(tpr_q), .isr_top(svc_top), .ppr(ppr_w));

    always_comb begin
        ack_r.take = ack_granted(sw_en, req_top, tpr_q);
        ack_r.vec  = ack_r.take ? req_top.vec : spur_q[VEC_W-1:0];
        ack_r.lvl  = ack_r.take & trg_q[req_top.vec];
    end

    always_comb begin
        req_d = req_q;
        svc_d = svc_q;
        trg_d = trg_q;
        if (eoi && svc_top.found)
            svc_d[svc_top.vec] = 1'b0;
        if (ack && ack_r.take) begin
            req_d[req_top.vec] = 1'b0;
            svc_d[req_top.vec] = 1'b1;
        end
        if (set_vld) begin
            req_d[set_vec] = 1'b1;
            trg_d[set_vec] = set_level;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '0;
            svc_q  <= '0;
            trg_q  <= '0;
            tpr_q  <= '0;
            spur_q <= SPUR_W'(9'h0FF);
            irq_q  <= 1'b0;
        end else begin
            req_q <= req_d;
            svc_q <= svc_d;
            trg_q <= trg_d;
            if (tpr_we)  tpr_q  <= tpr_wdata;
            if (spur_we) spur_q <= spur_wdata[SPUR_W-1:0];
            irq_q <= irq_wanted(sw_en, req_top, ppr_w);
        end
    end

    assign ack_vec   = ack_r.vec;
    assign ack_level = ack_r.lvl;
    assign irq       = irq_q;
    assign ppr       = ppr_w;

    // R2: a disabled controller never raises the line on the next clock
    a_r2_disabled_no_irq: assert property (@(posedge clk) disable iff (rst)
        !sw_en |=> !irq_q);

    // R4: processor priority never falls below the task priority
    a_r4_ppr_floor: assert property (@(posedge clk) disable iff (rst)
        ppr_w >= tpr_q);

    // R7: the encoder only reports a vector whose request bit is set
    a_r7_hit_is_set: assert property (@(posedge clk) disable iff (rst)
        req_top.found |-> req_q[req_top.vec]);

    // R7: a granted acknowledge moves exactly one vector from pending to in service
    a_r7_ack_moves: assert property (@(posedge clk) disable iff (rst)
        (ack && ack_r.take && !eoi && !set_vld) |=>
        ($countones(svc_q) == $past($countones(svc_q)) + 1) &&
        ($countones(req_q) == $past($countones(req_q)) - 1));

    // R8: a refused acknowledge leaves both maps untouched
    a_r8_refused_stable: assert property (@(posedge clk) disable iff (rst)
        (ack && !ack_r.take && !eoi && !set_vld) |=> $stable(req_q) && $stable(svc_q));

    // R9: end-of-interrupt with nothing in service changes nothing
    a_r9_eoi_empty_stable: assert property (@(posedge clk) disable iff (rst)
        (eoi && !svc_top.found && !ack) |=> $stable(svc_q));

    // R9: end-of-interrupt retires exactly one vector
    a_r9_eoi_one: assert property (@(posedge clk) disable iff (rst)
        (eoi && svc_top.found && !ack) |=>
        $countones(svc_q) == $past($countones(svc_q)) - 1);
endmodule

// File: tb/sim_vip_ctrl.sv
module sim_vip_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;
    localparam int NTBL       = 8;
    // each entry: {task priority, vector, expected irq}
    localparam logic [16:0] TBL [NTBL] = '{
        {8'h00, 8'h10, 1'b1},
        {8'h20, 8'h2F, 1'b0},
        {8'h20, 8'h30, 1'b1},
        {8'h5A, 8'h5B, 1'b0},
        {8'hF0, 8'hFF, 1'b0},
        {8'h0F, 8'h10, 1'b1},
        {8'h0F, 8'h05, 1'b0},
        {8'h00, 8'h00, 1'b1}
    };

    logic clk = 1'b0;
    logic rst;
    logic set_vld, set_level, tpr_we, spur_we, ack, eoi;
    logic [7:0] set_vec, tpr_wdata, ack_vec, ppr;
    logic [31:0] spur_wdata;
    logic ack_level, irq;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] gv;
    logic       gl;

    always #(CLK_PERIOD/2) clk = ~clk;

    vip_ctrl u0 (
        .clk(clk), .rst(rst), .set_vld(set_vld), .set_vec(set_vec), .set_level(set_level),
        .tpr_we(tpr_we), .tpr_wdata(tpr_wdata), .spur_we(spur_we), .spur_wdata(spur_wdata),
        .ack(ack), .ack_vec(ack_vec), .ack_level(ack_level), .eoi(eoi), .irq(irq), .ppr(ppr));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs();
        set_vld = 0; set_vec = 0; set_level = 0; tpr_we = 0; tpr_wdata = 0;
        spur_we = 0; spur_wdata = 0; ack = 0; eoi = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        idle_inputs();
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
    endtask

    task automatic settle();
        @(negedge clk);
        #1;
    endtask

    task automatic wr_tpr(input logic [7:0] v);
        @(negedge clk); tpr_we = 1; tpr_wdata = v;
        @(negedge clk); tpr_we = 0;
    endtask

    task automatic wr_spur(input logic [31:0] v);
        @(negedge clk); spur_we = 1; spur_wdata = v;
        @(negedge clk); spur_we = 0;
    endtask

    task automatic raise(input logic [7:0] v, input logic lvl);
        @(negedge clk); set_vld = 1; set_vec = v; set_level = lvl;
        @(negedge clk); set_vld = 0;
    endtask

    task automatic do_eoi();
        @(negedge clk); eoi = 1;
        @(negedge clk); eoi = 0;
    endtask

    task automatic do_ack(output logic [7:0] v, output logic l);
        @(negedge clk); ack = 1;
        #1; v = ack_vec; l = ack_level;
        @(negedge clk); ack = 0;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        do_reset();
        settle();
        // R1: reset state
        chk("R1 irq after reset", 32'(irq), 0);
        chk("R1 ppr after reset", 32'(ppr), 0);
        do_ack(gv, gl);
        chk("R1 reset spurious vector", 32'(gv), 32'hFF);
        // R2: disabled controller holds the line low and refuses acknowledge
        raise(8'h40, 0);
        settle();
        chk("R2 disabled irq", 32'(irq), 0);
        do_ack(gv, gl);
        chk("R2 disabled ack spurious", 32'(gv), 32'hFF);
        wr_spur(32'h0000_010F);
        settle();
        chk("R2 enabled irq, request kept", 32'(irq), 1);

        // R5 and R4: table walk
        for (int i = 0; i < NTBL; i++) begin
            do_reset();
            wr_spur(32'h0000_010F);
            wr_tpr(TBL[i][16:9]);
            raise(TBL[i][8:1], 0);
            settle();
            chk($sformatf("R5 table entry %0d irq", i), 32'(irq), 32'(TBL[i][0]));
            chk($sformatf("R4 table entry %0d ppr", i), 32'(ppr), 32'(TBL[i][16:9]));
        end

        // R6: registered line lags the state update by one clock
        do_reset();
        wr_spur(32'h0000_010F);
        @(negedge clk); set_vld = 1; set_vec = 8'h66; set_level = 0;
        @(negedge clk); set_vld = 0; #1;
        chk("R6 irq not yet raised", 32'(irq), 0);
        settle();
        chk("R6 irq raised one clock later", 32'(irq), 1);

        // R3 R7 R9: ordering, trigger flags and retirement
        do_reset();
        wr_spur(32'h0000_010F);
        raise(8'h31, 0);
        raise(8'h87, 1);
        raise(8'h45, 1);
        raise(8'h45, 0);
        settle();
        chk("R5 irq with three pending", 32'(irq), 1);
        do_ack(gv, gl);
        chk("R7 ack highest 87", 32'(gv), 32'h87);
        chk("R3 level flag of 87", 32'(gl), 1);
        settle();
        chk("R4 ppr from service class 8", 32'(ppr), 32'h80);
        chk("R5 irq blocked by service class", 32'(irq), 0);
        do_ack(gv, gl);
        chk("R7 ack next 45", 32'(gv), 32'h45);
        chk("R3 overwritten flag of 45 is edge", 32'(gl), 0);
        do_eoi();
        settle();
        chk("R9 eoi retires 87 only", 32'(ppr), 32'h40);
        do_ack(gv, gl);
        chk("R7 ack last 31", 32'(gv), 32'h31);
        do_eoi();
        settle();
        chk("R9 eoi retires 45 not 31", 32'(ppr), 32'h30);
        do_eoi();
        settle();
        chk("R9 eoi empties service", 32'(ppr), 0);
        do_eoi();
        settle();
        chk("R9 eoi on empty map", 32'(ppr), 0);
        do_ack(gv, gl);
        chk("R8 nothing pending spurious", 32'(gv), 32'h0F);
        chk("R3 refused ack level low", 32'(gl), 0);

        // R4: task priority against service class
        wr_tpr(8'h85);
        raise(8'h90, 0);
        do_ack(gv, gl);
        chk("R7 ack 90 above tpr", 32'(gv), 32'h90);
        settle();
        chk("R4 service class wins", 32'(ppr), 32'h90);
        wr_tpr(8'h95);
        settle();
        chk("R4 equal class keeps full tpr byte", 32'(ppr), 32'h95);
        do_eoi();
        wr_tpr(8'h00);

        // R8: acknowledge refused by task priority
        wr_tpr(8'h50);
        raise(8'h50, 1);
        settle();
        chk("R5 equal class no irq", 32'(irq), 0);
        do_ack(gv, gl);
        chk("R8 blocked ack spurious", 32'(gv), 32'h0F);
        settle();
        chk("R8 blocked ack leaves service empty", 32'(ppr), 32'h50);
        wr_tpr(8'h00);
        settle();
        chk("R8 request survives blocked ack", 32'(irq), 1);
        do_ack(gv, gl);
        chk("R8 request granted later", 32'(gv), 32'h50);
        chk("R3 level flag of 50", 32'(gl), 1);
        do_eoi();

        // R2: only bits 8:0 are kept
        wr_spur(32'hFFFF_FE33);
        raise(8'h20, 0);
        settle();
        chk("R2 bit 8 clear disables", 32'(irq), 0);
        do_ack(gv, gl);
        chk("R2 low byte as spurious", 32'(gv), 32'h33);
        wr_spur(32'h0000_0133);
        settle();
        chk("R2 re-enabled irq", 32'(irq), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule